// File: doc/BRIEF.md
# Split-Address Chip Identification Reader

This controller sits above a byte-level I2C master and fetches three identification bytes from a target that accepts register-offset writes on one 7-bit address and returns register data on a different 7-bit address. For every register it issues a one-byte write of the offset to the command address, which the master closes with a STOP. It then issues a separate one-byte read from the data address. It does not use a repeated START. The offsets are fetched in the fixed order 0, 1, 2. The first byte is a vendor identifier, the second a secondary identifier and the third a version byte.

When all three bytes are captured, the block compares the vendor identifier with the expected value. It also splits the version byte into a revision code and a flash-size code, and looks up the flash size in a table chosen by the revision class. It reports the result with a one-cycle `valid` pulse. If the master reports a failure on any transaction, the remaining accesses are dropped and a one-cycle `fail` pulse is raised with a bus error code.

The command channel is valid/ready. Once `cmd_valid` rises, the controller holds `cmd_rd`, `cmd_addr` and `cmd_wdata` steady until a cycle in which `cmd_ready` is high. That cycle is the transfer. The response channel is also valid/ready. `rsp_ready` is high only while a response is awaited, and a response counts only in a cycle where both `rsp_valid` and `rsp_ready` are high. The master must hold its response until then. `start` is a plain pulse.

Top module: `chipid_reader`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `valid` and `fail` are 0 and `err_code` is 0 (0 = no error).
- R2: Each register access is a write command (`cmd_rd`=0) to address 0x5A carrying the offset in `cmd_wdata`. After its response comes a read command (`cmd_rd`=1) to address 0x35.
- R3: Offsets are fetched in the order 0x00, 0x01, 0x02. The read data lands on `id1`, `id2` and `ver` respectively.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_rd`, `cmd_addr` and `cmd_wdata` stay unchanged into the next cycle.
- R5: A response with `rsp_err`=1 ends the run. `fail` pulses for one cycle in the cycle after that response, `err_code` becomes 1 (bus error), `busy` drops and no further command is issued.
- R6: `valid` pulses for exactly one cycle, in the cycle after the third read response is accepted. It pulses whether or not the vendor check passes, and never together with `fail`.
- R7: `rev` equals `ver[2:0]` (bit 3 is ignored). Values 0 to 2 are the early class, 3 is the late class, and 4 to 7 raise `rev_unknown` with `size_kb`=0.
- R8: In the early class, `ver[7:4]` values 0, 4 and 8 give `size_kb` 128, 192 and 256.
- R9: In the late class, `ver[7:4]` values 0, 2, 4, 6 and 8 give `size_kb` 128, 192, 256, 384 and 512.
- R10: Any other size code gives `size_kb`=0 and raises `size_unk_early` (early class) or `size_unk_late` (late class). At most one of the three flags is high at a time.
- R11: With `valid`, `err_code` is 2 (identification error) if `id1` is not 0x83, and 0 otherwise.
- R12: `start` while `busy` is ignored: the running sequence continues unchanged and produces a single result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a read-out |
| busy | output | 1 | Read-out in progress |
| cmd_valid | output | 1 | Command offered to the byte master |
| cmd_ready | input | 1 | Byte master takes the command |
| cmd_rd | output | 1 | 1 = one-byte read, 0 = one-byte write |
| cmd_addr | output | 7 | 7-bit target address |
| cmd_wdata | output | 8 | Byte to write (register offset) |
| rsp_valid | input | 1 | Byte master has a transaction result |
| rsp_ready | output | 1 | Controller awaits a result |
| rsp_data | input | 8 | Byte read (ignored for writes) |
| rsp_err | input | 1 | Transaction failed |
| id1 | output | 8 | Captured vendor identifier |
| id2 | output | 8 | Captured secondary identifier |
| ver | output | 8 | Captured version byte |
| rev | output | 3 | Revision code |
| size_kb | output | 10 | Flash size in KB, 0 when unknown |
| size_unk_early | output | 1 | Unmapped size code, early class |
| size_unk_late | output | 1 | Unmapped size code, late class |
| rev_unknown | output | 1 | Revision code above the late class |
| valid | output | 1 | One-cycle result pulse |
| fail | output | 1 | One-cycle abort pulse |
| err_code | output | 2 | 0 none, 1 bus error, 2 identification error |

## Verification
The bench builds the block with its default parameters: command address 0x5A, data address 0x35, vendor value 0x83 and three registers. With these, each run makes the full six-transaction pattern and all three offsets. A bench-side target model stalls `cmd_ready` for zero to three cycles and injects a failure at a chosen transaction number. That reaches back-pressure on both command kinds and aborts after the first, middle and last transaction. Sweeping all sixteen size codes for an early and a late revision covers every table entry and every unmapped code.

// File: rtl/chipid_pkg.sv
package chipid_pkg;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_BUS  = 2'd1,
    ERR_ID   = 2'd2
  } err_e;

  typedef enum logic [1:0] {
    CLS_EARLY = 2'd0,
    CLS_LATE  = 2'd1,
    CLS_BAD   = 2'd2
  } rev_class_e;

  localparam int SIZE_W = 10;

  localparam logic [SIZE_W-1:0] KB_128 = SIZE_W'(128);
  localparam logic [SIZE_W-1:0] KB_192 = SIZE_W'(192);
  localparam logic [SIZE_W-1:0] KB_256 = SIZE_W'(256);
  localparam logic [SIZE_W-1:0] KB_384 = SIZE_W'(384);
  localparam logic [SIZE_W-1:0] KB_512 = SIZE_W'(512);

endpackage

// File: rtl/chipid_seq.sv
module chipid_seq
  import chipid_pkg::*;
#(
  parameter logic [6:0] CMD_ADDR  = 7'h5A,
  parameter logic [6:0] DATA_ADDR = 7'h35,
  parameter logic [7:0] VENDOR_ID = 8'h83,
  parameter logic [7:0] REG_BASE  = 8'h00,
  parameter int         NUM_REGS  = 3,
  localparam int        IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic             cmd_rd,
  output logic [6:0]       cmd_addr,
  output logic [7:0]       cmd_wdata,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_err,
  input  logic [7:0]       id_first,
  output logic             clr,
  output logic             cap_en,
  output logic [IDX_W-1:0] cap_idx,
  output logic             valid,
  output logic             fail,
  output logic [1:0]       err_code
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_WCMD,
    S_WRSP,
    S_RCMD,
    S_RRSP
  } state_e;

  state_e           state;
  logic [IDX_W-1:0] idx;
  logic             rsp_take;
  logic [7:0]       vendor_byte;

  assign busy      = (state != S_IDLE);
  assign cmd_valid = (state == S_WCMD) || (state == S_RCMD);
  assign cmd_rd    = (state == S_RCMD);
  assign cmd_addr  = cmd_rd ? DATA_ADDR : CMD_ADDR;
  assign cmd_wdata = REG_BASE + 8'(idx);
  assign rsp_ready = (state == S_WRSP) || (state == S_RRSP);
  assign rsp_take  = rsp_ready && rsp_valid;
  assign clr       = (state == S_IDLE) && start;
  assign cap_en    = (state == S_RRSP) && rsp_valid && !rsp_err;
  assign cap_idx   = idx;
  // the vendor byte may be arriving in this very response when only one register exists
  assign vendor_byte = (idx == '0) ? rsp_data : id_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      valid    <= 1'b0;
      fail     <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      valid <= 1'b0;
      fail  <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_WCMD;
            idx      <= '0;
            err_code <= ERR_NONE;
          end
        end
        S_WCMD: if (cmd_ready) state <= S_WRSP;
        S_RCMD: if (cmd_ready) state <= S_RRSP;
        S_WRSP, S_RRSP: begin
          if (rsp_take) begin
            if (rsp_err) begin
              fail     <= 1'b1;
              err_code <= ERR_BUS;
              state    <= S_IDLE;
            end else if (state == S_WRSP) begin
              state <= S_RCMD;
            end else if (idx == LAST_IDX) begin
              valid    <= 1'b1;
              err_code <= (vendor_byte != VENDOR_ID) ? ERR_ID : ERR_NONE;
              state    <= S_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_WCMD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_rd) && $stable(cmd_addr) && $stable(cmd_wdata));

  assert_write_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_rd |-> cmd_addr == CMD_ADDR);

  assert_read_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_rd |-> cmd_addr == DATA_ADDR);

  assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_err |=> fail && !busy && !cmd_valid);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_valid_fail_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && fail));

  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !rsp_take |=> $stable(idx));

endmodule

// File: rtl/chipid_capture.sv
module chipid_capture #(
  parameter int  NUM_REGS = 3,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  cap_en,
  input  logic [IDX_W-1:0]      cap_idx,
  input  logic [7:0]            cap_data,
  output logic [NUM_REGS*8-1:0] bytes_out
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  slot_q <= '0;
      else if (clr)                                slot_q <= '0;
      else if (cap_en && cap_idx == IDX_W'(g))     slot_q <= cap_data;
    end
    assign bytes_out[g*8 +: 8] = slot_q;
  end

endmodule

// File: rtl/chipid_decode.sv
module chipid_decode
  import chipid_pkg::*;
#(
  parameter logic [2:0] LATE_REV = 3'd3
) (
  input  logic [7:0]        ver,
  output logic [2:0]        rev,
  output rev_class_e        rev_class,
  output logic [SIZE_W-1:0] size_kb,
  output logic              size_unk_early,
  output logic              size_unk_late,
  output logic              rev_unknown
);

  logic [3:0]        size_code;
  logic [SIZE_W-1:0] early_kb;
  logic [SIZE_W-1:0] late_kb;
  logic              early_hit;
  logic              late_hit;
  logic              unused_ver_bit3;

  assign rev             = ver[2:0];
  assign size_code       = ver[7:4];
  assign unused_ver_bit3 = ver[3];

  always_comb begin
    if (rev < LATE_REV)       rev_class = CLS_EARLY;
    else if (rev == LATE_REV) rev_class = CLS_LATE;
    else                      rev_class = CLS_BAD;
  end

  always_comb begin
    early_hit = 1'b1;
    unique case (size_code)
      4'd0:    early_kb = KB_128;
      4'd4:    early_kb = KB_192;
      4'd8:    early_kb = KB_256;
      default: begin early_kb = '0; early_hit = 1'b0; end
    endcase
  end

  always_comb begin
    late_hit = 1'b1;
    unique case (size_code)
      4'd0:    late_kb = KB_128;
      4'd2:    late_kb = KB_192;
      4'd4:    late_kb = KB_256;
      4'd6:    late_kb = KB_384;
      4'd8:    late_kb = KB_512;
      default: begin late_kb = '0; late_hit = 1'b0; end
    endcase
  end

  always_comb begin
    size_kb        = '0;
    size_unk_early = 1'b0;
    size_unk_late  = 1'b0;
    rev_unknown    = 1'b0;
    unique case (rev_class)
      CLS_EARLY: begin size_kb = early_kb; size_unk_early = !early_hit; end
      CLS_LATE:  begin size_kb = late_kb;  size_unk_late  = !late_hit;  end
      default:   rev_unknown = 1'b1;
    endcase
  end

endmodule

// File: rtl/chipid_reader.sv
module chipid_reader
  import chipid_pkg::*;
#(
  parameter logic [6:0] CMD_ADDR  = 7'h5A,
  parameter logic [6:0] DATA_ADDR = 7'h35,
  parameter logic [7:0] VENDOR_ID = 8'h83,
  parameter logic [2:0] LATE_REV  = 3'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic        cmd_rd,
  output logic [6:0]  cmd_addr,
  output logic [7:0]  cmd_wdata,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_data,
  input  logic        rsp_err,
  output logic [7:0]  id1,
  output logic [7:0]  id2,
  output logic [7:0]  ver,
  output logic [2:0]  rev,
  output logic [9:0]  size_kb,
  output logic        size_unk_early,
  output logic        size_unk_late,
  output logic        rev_unknown,
  output logic        valid,
  output logic        fail,
  output logic [1:0]  err_code
);

  localparam int NUM_REGS = 3;
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                  clr;
  logic                  cap_en;
  logic [IDX_W-1:0]      cap_idx;
  logic [NUM_REGS*8-1:0] bytes_q;
  rev_class_e            rev_class;
  logic [SIZE_W-1:0]     size_w;

  chipid_seq #(
    .CMD_ADDR (CMD_ADDR),
    .DATA_ADDR(DATA_ADDR),
    .VENDOR_ID(VENDOR_ID),
    .REG_BASE (8'h00),
    .NUM_REGS (NUM_REGS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_rd   (cmd_rd),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data),
    .rsp_err  (rsp_err),
    .id_first (bytes_q[7:0]),
    .clr      (clr),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .valid    (valid),
    .fail     (fail),
    .err_code (err_code)
  );

  chipid_capture #(
    .NUM_REGS(NUM_REGS)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_data (rsp_data),
    .bytes_out(bytes_q)
  );

  assign id1 = bytes_q[7:0];
  assign id2 = bytes_q[15:8];
  assign ver = bytes_q[23:16];

  chipid_decode #(
    .LATE_REV(LATE_REV)
  ) u_dec (
    .ver           (ver),
    .rev           (rev),
    .rev_class     (rev_class),
    .size_kb       (size_w),
    .size_unk_early(size_unk_early),
    .size_unk_late (size_unk_late),
    .rev_unknown   (rev_unknown)
  );

  assign size_kb = size_w;

  assert_flags_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({size_unk_early, size_unk_late, rev_unknown}));

  assert_unknown_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (size_unk_early || size_unk_late) |-> size_kb == '0);

  assert_bad_rev_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && rev > LATE_REV |-> rev_unknown && size_kb == '0 && rev_class == CLS_BAD);

  assert_valid_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> err_code != ERR_BUS);

  assert_fail_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> err_code == ERR_BUS);

endmodule

// File: tb/tb_chipid_reader.sv
module tb_chipid_reader;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, cmd_valid, cmd_rd, rsp_ready;
  logic       cmd_ready = 1'b0;
  logic [6:0] cmd_addr;
  logic [7:0] cmd_wdata;
  logic       rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic       rsp_err = 1'b0;
  logic [7:0] id1, id2, ver;
  logic [2:0] rev;
  logic [9:0] size_kb;
  logic       size_unk_early, size_unk_late, rev_unknown, valid, fail;
  logic [1:0] err_code;

  always #4 clk = ~clk;

  chipid_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .id1(id1), .id2(id2), .ver(ver), .rev(rev), .size_kb(size_kb),
    .size_unk_early(size_unk_early), .size_unk_late(size_unk_late),
    .rev_unknown(rev_unknown), .valid(valid), .fail(fail), .err_code(err_code)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    bit         is_fail;
    logic [1:0] err;
    logic [7:0] b1, b2, b3;
    logic [2:0] rev;
    logic [9:0] size;
    bit         ue, ul, ru;
  } exp_t;

  exp_t exp_q[$];
  int   results = 0;

  // target model state
  logic [7:0] regs [3];
  int         fail_at = -1;
  int         stall = 0;
  int         txn = 0;

  function automatic exp_t model(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    exp_t e;
    e.is_fail = 0; e.b1 = a; e.b2 = b; e.b3 = c;
    e.err = (a == 8'h83) ? 2'd0 : 2'd2;
    e.rev = c[2:0]; e.size = 0; e.ue = 0; e.ul = 0; e.ru = 0;
    if (c[2:0] < 3) begin
      case (c[7:4])
        4'd0: e.size = 128;
        4'd4: e.size = 192;
        4'd8: e.size = 256;
        default: e.ue = 1;
      endcase
    end else if (c[2:0] == 3) begin
      case (c[7:4])
        4'd0: e.size = 128;
        4'd2: e.size = 192;
        4'd4: e.size = 256;
        4'd6: e.size = 384;
        4'd8: e.size = 512;
        default: e.ul = 1;
      endcase
    end else e.ru = 1;
    return e;
  endfunction

  // target model: responds to commands, checks order and addressing (R2, R3, R4)
  initial begin
    logic [7:0] last_off;
    logic       s_rd;
    logic [6:0] s_addr;
    logic [7:0] s_wd;
    last_off = 8'h00;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        s_rd = cmd_rd; s_addr = cmd_addr; s_wd = cmd_wdata;
        check(s_rd == (txn % 2 == 1), "R2 command kind", int'(s_rd), txn % 2);
        check(s_addr == ((txn % 2 == 1) ? 7'h35 : 7'h5A), "R2 command address", s_addr,
              (txn % 2 == 1) ? 7'h35 : 7'h5A);
        if (!s_rd) check(s_wd == 8'(txn / 2), "R3 offset order", s_wd, txn / 2);
        for (int k = 0; k < stall; k++) begin
          @(negedge clk);
          check(cmd_valid && cmd_rd == s_rd && cmd_addr == s_addr && cmd_wdata == s_wd,
                "R4 command held under back-pressure", {cmd_valid, cmd_addr}, {1'b1, s_addr});
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        @(negedge clk);
        if (!s_rd) last_off = s_wd;
        rsp_data  = s_rd ? regs[last_off[1:0]] : 8'h00;
        rsp_err   = (txn == fail_at);
        rsp_valid = 1'b1;
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        txn++;
      end
    end
  end

  // monitor / scoreboard
  logic prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pulse) check(!valid && !fail, "R6 single-cycle result pulse", valid, 0);
      if (valid || fail) begin
        if (exp_q.size() == 0) begin
          check(0, "R12 unexpected extra result", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(fail == e.is_fail && valid == !e.is_fail && !(valid && fail),
                "R5/R6 result kind", {valid, fail}, {!e.is_fail, e.is_fail});
          check(err_code == e.err, e.is_fail ? "R5 bus error code" : "R11 id check code",
                err_code, e.err);
          if (!e.is_fail) begin
            check({id1, id2, ver} == {e.b1, e.b2, e.b3}, "R3 captured bytes",
                  {id1, id2, ver}, {e.b1, e.b2, e.b3});
            check(rev == e.rev, "R7 revision", rev, e.rev);
            check(size_kb == e.size, "R8/R9 size", size_kb, e.size);
            check(size_unk_early == e.ue, "R10 early unknown flag", size_unk_early, e.ue);
            check(size_unk_late == e.ul, "R10 late unknown flag", size_unk_late, e.ul);
            check(rev_unknown == e.ru, "R7 unrecognized revision", rev_unknown, e.ru);
          end
        end
        results++;
      end
      prev_pulse = valid || fail;
    end
  end

  task automatic run(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                     input int f_at, input int st, input bit restart);
    exp_t e;
    int   want;
    regs[0] = a; regs[1] = b; regs[2] = c;
    fail_at = f_at; stall = st; txn = 0;
    if (f_at >= 0) begin
      e = model(a, b, c);
      e.is_fail = 1; e.err = 2'd1;
    end else e = model(a, b, c);
    exp_q.push_back(e);
    want = results + 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (results < want) @(negedge clk);
    repeat (4) @(negedge clk);
    check(!busy && !cmd_valid, f_at >= 0 ? "R5 no command after abort" : "R12 idle after run",
          {busy, cmd_valid}, 0);
    if (f_at >= 0) check(txn == f_at + 1, "R5 transactions before abort", txn, f_at + 1);
    else           check(txn == 6, "R12 single sequence of six transactions", txn, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !cmd_valid && !valid && !fail && err_code == 0, "R1 reset state",
          {busy, cmd_valid, valid, fail, err_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !cmd_valid && !valid && !fail && err_code == 0, "R1 after reset release",
          {busy, cmd_valid, valid, fail, err_code}, 0);

    run(8'h83, 8'h02, 8'h41, -1, 0, 0);   // early, 192 KB
    run(8'h83, 8'h20, 8'h63, -1, 2, 0);   // late, 384 KB, stalled
    run(8'h83, 8'h20, 8'h8B, -1, 1, 0);   // bit 3 ignored -> late, 512 KB
    run(8'h83, 8'h11, 8'h05, -1, 0, 0);   // unrecognized revision
    run(8'h83, 8'h11, 8'hF7, -1, 3, 0);   // unrecognized revision, large code
    run(8'h12, 8'h34, 8'h80, -1, 0, 0);   // R11 id mismatch, still valid
    for (int n = 0; n < 16; n++) run(8'h83, 8'h00, {4'(n), 4'h0}, -1, n % 4, 0); // R8 early sweep
    for (int n = 0; n < 16; n++) run(8'h83, 8'h00, {4'(n), 4'h3}, -1, n % 3, 0); // R9 late sweep
    run(8'h83, 8'h01, 8'h02, 0, 0, 0);    // R5 abort on first write
    run(8'h83, 8'h01, 8'h02, 3, 1, 0);    // R5 abort mid-run
    run(8'h83, 8'h01, 8'h02, 5, 2, 0);    // R5 abort on final read
    run(8'h83, 8'h44, 8'h23, -1, 2, 1);   // R12 start while busy
    run(8'h83, 8'h55, 8'h01, -1, 0, 0);   // recovery after earlier runs

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule